// File: doc/BRIEF.md
# Configurable-Timing 8-bit External Bus Controller

This controller turns single-beat requests from a CPU-side port into read and write cycles on an 8-bit external bus. A request gives a 16-bit address, a direction, write data and a mode flag. The block runs the external cycle in three phases: setup, an active-low strobe, and hold. It then returns a one-cycle completion pulse, along with the captured byte on reads.

The length of each phase comes from a configuration byte that holds two independent timing sets. The low nibble times accesses below 8000h and the high nibble times accesses at 8000h and above. Each nibble is laid out as {setup bit, hold bit, width[1:0]}. The byte is written through a small config port and every bit comes out of reset as 1.

In direct mode, address bits 7:0 appear on their own pins. In multiplexed mode the low address byte is placed on the data pins at the start of setup, and a one-cycle active-high latch pulse lets an external register capture it. Address bits 14:8 and bit 15 are always driven on dedicated pins. Two active-low selects decode the address ranges 4000h–7FFFh and 8000h–FFFFh.

Top module: `ebus_ctrl`

## Requirements
- R1: Reset state: the configuration byte equals FFh; `bus_rd_n`, `bus_wr_n`, `bus_cs0_n` and `bus_cs1_n` are high; `bus_ale`, `bus_data_oe` and `rsp_done` are low; `rsp_rdata` is 00h.
- R2: Setup lasts 2 cycles when the selected set's setup bit is 0, and 3 cycles when it is 1. The setup bit is bit 3 for set 0 and bit 7 for set 1. If a request is accepted at clock edge 0, setup occupies cycles 1..S.
- R3: The strobe lasts width+1 cycles (1 to 4). Width is bits 1:0 for set 0 and bits 5:4 for set 1. Only `bus_rd_n` falls on a read and only `bus_wr_n` falls on a write; the two are never low together.
- R4: Hold lasts 1 cycle when the selected hold bit is 0, and 2 cycles when it is 1. The hold bit is bit 2 for set 0 and bit 6 for set 1. The strobe is high during hold while the address and selects stay driven.
- R5: Address bit 15 of the accepted request selects the timing set: 0 selects set 0 and 1 selects set 1.
- R6: A request is accepted only while the controller is idle. `req_valid` during an access is ignored. `rsp_done` is high for exactly one cycle, the cycle right after the last hold cycle, and the controller is idle in the cycle after that.
- R7: On a read, `rsp_rdata` takes the value on `bus_data_i` at the clock edge where `bus_rd_n` returns high. It keeps that value until the next read.
- R8: During setup, strobe and hold, `bus_cs0_n` is low exactly when address bits 15:14 are 01, and `bus_cs1_n` is low exactly when address bit 15 is 1. `bus_addr_hi` carries address bits 14:8 and `bus_a15` carries bit 15. Both selects are high otherwise.
- R9: In direct mode (`req_mux`=0), `bus_addr_lo` carries address bits 7:0 during the access and `bus_ale` stays low.
- R10: In multiplexed mode, `bus_ale` is high only in setup cycle 1, and `bus_data_o` carries address bits 7:0 with `bus_data_oe` high in setup cycles 1 and 2. `bus_addr_lo` is 00h.
- R11: On a write, `bus_data_oe` is high and `bus_data_o` equals the write data from the end of the address phase (or from setup cycle 1 in direct mode) through the last hold cycle. On a read, `bus_data_oe` is low outside the address phase.
- R12: The timing set is captured when the request is accepted. A config write during an access does not change the phases of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_wdata | input | 8 | New configuration byte |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mux | input | 1 | 1 = multiplexed low address, 0 = direct |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last captured read byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ale | output | 1 | Low-address latch pulse, active high |
| bus_cs0_n | output | 1 | Select for 4000h–7FFFh, active low |
| bus_cs1_n | output | 1 | Select for 8000h–FFFFh, active low |
| bus_addr_lo | output | 8 | Direct-mode address bits 7:0 |
| bus_addr_hi | output | 7 | Address bits 14:8 |
| bus_a15 | output | 1 | Address bit 15 |
| bus_data_o | output | 8 | Data bus output value |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_data_i | input | 8 | Data bus input value |

## Verification
Several properties are checked on every cycle: the two strobes are never low together, the selects are mutually exclusive, a read never drives the data bus while its strobe is low, the latch pulse lasts one cycle and comes with the data bus driven, the completion pulse lasts one cycle, and the returned read byte changes only as the read strobe rises. Other behaviour depends on counting cycles across phases, and only the bench sweep shows it. That covers the exact setup, strobe and hold lengths for every configuration byte and both timing sets, the range decode at the region boundaries, the sampling instant for read data, requests that are ignored while busy, and config writes made mid-access.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 8;
    localparam int HI_W         = ADDR_W - DATA_W - 1;
    localparam int CNT_W        = 3;
    localparam int NUM_SETS     = 2;
    localparam int SET_BITS     = 4;
    localparam int CFG_W        = NUM_SETS * SET_BITS;
    localparam int ADDR_PH_CYC  = 2;
    localparam logic [CFG_W-1:0] CFG_RESET = {CFG_W{1'b1}};
    localparam logic [1:0]       CS0_TAG   = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup_len;
        logic [CNT_W-1:0] hold_len;
        logic [CNT_W-1:0] strobe_len;
    } timing_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              mux;
    } xfer_t;

    // nibble layout: [3] setup, [2] hold, [1:0] strobe width
    function automatic timing_t decode_set(input logic [SET_BITS-1:0] nib);
        timing_t t;
        t.setup_len  = nib[3] ? CNT_W'(3) : CNT_W'(2);
        t.hold_len   = nib[2] ? CNT_W'(2) : CNT_W'(1);
        t.strobe_len = CNT_W'(nib[1:0]) + CNT_W'(1);
        return t;
    endfunction

    function automatic logic phase_end(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] len);
        return cnt == (len - CNT_W'(1));
    endfunction

endpackage

// File: rtl/ebus_cfg_reg.sv
module ebus_cfg_reg
    import ebus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= CFG_RESET;
        else if (we)
            q <= wdata;
    end

endmodule

// File: rtl/ebus_timing_sel.sv
module ebus_timing_sel
    import ebus_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             addr_msb,
    output timing_t          timing
);

    timing_t sets [NUM_SETS];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        assign sets[g] = decode_set(cfg[g*SET_BITS +: SET_BITS]);
    end

    assign timing = sets[addr_msb];

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xfer_t             req,
    input  timing_t           timing,
    input  logic [DATA_W-1:0] data_in,
    output phase_t            phase,
    output logic [CNT_W-1:0]  cnt,
    output xfer_t             cur,
    output logic [DATA_W-1:0] rdata
);

    timing_t tim;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
            tim   <= '0;
            rdata <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur   <= req;
                        tim   <= timing;
                        cnt   <= '0;
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (phase_end(cnt, tim.setup_len)) begin
                        cnt   <= '0;
                        phase <= PH_STROBE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (phase_end(cnt, tim.strobe_len)) begin
                        cnt   <= '0;
                        phase <= PH_HOLD;
                        if (!cur.write)
                            rdata <= data_in;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (phase_end(cnt, tim.hold_len)) begin
                        cnt   <= '0;
                        phase <= PH_DONE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ebus_pin_drv.sv
module ebus_pin_drv
    import ebus_pkg::*;
(
    input  phase_t            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  xfer_t             cur,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ale,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [DATA_W-1:0] addr_lo,
    output logic [HI_W-1:0]   addr_hi,
    output logic              a15,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              done
);

    logic busy;
    logic addr_ph;

    always_comb begin
        busy    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        addr_ph = cur.mux && (phase == PH_SETUP) && (cnt < CNT_W'(ADDR_PH_CYC));
        ale     = cur.mux && (phase == PH_SETUP) && (cnt == '0);
        data_oe = addr_ph || (busy && cur.write);
        data_o  = addr_ph ? cur.addr[DATA_W-1:0] : cur.wdata;
        rd_n    = !((phase == PH_STROBE) && !cur.write);
        wr_n    = !((phase == PH_STROBE) && cur.write);
        cs0_n   = !(busy && (cur.addr[ADDR_W-1 -: 2] == CS0_TAG));
        cs1_n   = !(busy && cur.addr[ADDR_W-1]);
        addr_lo = cur.mux ? '0 : cur.addr[DATA_W-1:0];
        addr_hi = cur.addr[ADDR_W-2:DATA_W];
        a15     = cur.addr[ADDR_W-1];
        done    = (phase == PH_DONE);
    end

endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mux,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_ale,
    output logic              bus_cs0_n,
    output logic              bus_cs1_n,
    output logic [DATA_W-1:0] bus_addr_lo,
    output logic [HI_W-1:0]   bus_addr_hi,
    output logic              bus_a15,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_i
);

    logic [CFG_W-1:0] cfg_q;
    timing_t          timing;
    xfer_t            req;
    xfer_t            cur;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    assign req = '{addr: req_addr, wdata: req_wdata, write: req_write, mux: req_mux};

    ebus_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    ebus_timing_sel u_tsel (
        .cfg      (cfg_q),
        .addr_msb (req_addr[ADDR_W-1]),
        .timing   (timing)
    );

    ebus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .timing    (timing),
        .data_in   (bus_data_i),
        .phase     (phase),
        .cnt       (cnt),
        .cur       (cur),
        .rdata     (rsp_rdata)
    );

    ebus_pin_drv u_pins (
        .phase   (phase),
        .cnt     (cnt),
        .cur     (cur),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .ale     (bus_ale),
        .cs0_n   (bus_cs0_n),
        .cs1_n   (bus_cs1_n),
        .addr_lo (bus_addr_lo),
        .addr_hi (bus_addr_hi),
        .a15     (bus_a15),
        .data_o  (bus_data_o),
        .data_oe (bus_data_oe),
        .done    (rsp_done)
    );

endmodule

// File: rtl/ebus_ctrl_chk.sv
module ebus_ctrl_chk
    import ebus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_ale,
    input logic              bus_cs0_n,
    input logic              bus_cs1_n,
    input logic              bus_data_oe,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [HI_W-1:0]   bus_addr_hi,
    input logic              bus_a15
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n)); // R3

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !bus_cs0_n |-> bus_cs1_n); // R8

    AST_ALE_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_data_oe && bus_rd_n && bus_wr_n)); // R10

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R6

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_data_oe); // R11

    AST_RDATA_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rsp_rdata) |-> $rose(bus_rd_n)); // R7

    AST_HOLD_PRESENT: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd_n) |-> !rsp_done); // R4

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n && $past(!bus_rd_n)) |-> ($stable(bus_addr_hi) && $stable(bus_a15))); // R8

endmodule

bind ebus_ctrl ebus_ctrl_chk u_chk (.*);

// File: tb/ebus_ctrl_tb.sv
module ebus_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_mux = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic        bus_rd_n, bus_wr_n, bus_ale, bus_cs0_n, bus_cs1_n;
    logic [7:0]  bus_addr_lo;
    logic [6:0]  bus_addr_hi;
    logic        bus_a15;
    logic [7:0]  bus_data_o;
    logic        bus_data_oe;
    logic [7:0]  bus_data_i = '0;

    int vectors = 0;
    int fails = 0;
    logic [7:0] exp_rdata = 8'h00;

    always #10 clk = ~clk;

    ebus_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_mux(req_mux),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ale(bus_ale),
        .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n),
        .bus_addr_lo(bus_addr_lo), .bus_addr_hi(bus_addr_hi), .bus_a15(bus_a15),
        .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i)
    );

    task automatic chk(input bit ok, input string req, input int k,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d act=%h exp=%h", req, k, act, exp);
        end
    endtask

    // One access; cfg_val is the byte in effect at acceptance.
    task automatic do_access(input logic [7:0] cfg_val, input bit load_cfg,
                             input bit mux, input bit wr,
                             input logic [15:0] addr, input logic [7:0] wd,
                             input logic [7:0] rv, input bit chg_cfg);
        logic [3:0] nib;
        int s, w, h, tot;
        bit busy, stb, addr_ph, oe_e;
        nib = addr[15] ? cfg_val[7:4] : cfg_val[3:0];          // R5
        s = nib[3] ? 3 : 2;                                     // R2
        h = nib[2] ? 2 : 1;                                     // R4
        w = int'(nib[1:0]) + 1;                                 // R3
        tot = s + w + h + 1;
        if (load_cfg) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_wdata = cfg_val;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_write = wr; req_mux = mux;
        req_addr = addr; req_wdata = wd; bus_data_i = ~rv;
        for (int k = 1; k <= tot + 1; k++) begin
            @(negedge clk);
            busy    = (k <= s + w + h);
            stb     = (k > s) && (k <= s + w);
            addr_ph = mux && (k <= 2);
            oe_e    = addr_ph || (busy && wr);
            chk(bus_rd_n == !(stb && !wr), "R3", k, 16'(bus_rd_n), 16'(!(stb && !wr)));
            chk(bus_wr_n == !(stb && wr), "R3", k, 16'(bus_wr_n), 16'(!(stb && wr)));
            chk(rsp_done == (k == tot), "R6", k, 16'(rsp_done), 16'(k == tot));
            chk(bus_ale == (mux && k == 1), "R10", k, 16'(bus_ale), 16'(mux && k == 1));
            chk(bus_data_oe == oe_e, "R11", k, 16'(bus_data_oe), 16'(oe_e));
            if (addr_ph)
                chk(bus_data_o == addr[7:0], "R10", k, 16'(bus_data_o), 16'(addr[7:0]));
            else if (oe_e)
                chk(bus_data_o == wd, "R11", k, 16'(bus_data_o), 16'(wd));
            chk(bus_cs0_n == !(busy && addr[15:14] == 2'b01), "R8", k,
                16'(bus_cs0_n), 16'(!(busy && addr[15:14] == 2'b01)));
            chk(bus_cs1_n == !(busy && addr[15]), "R8", k,
                16'(bus_cs1_n), 16'(!(busy && addr[15])));
            if (busy) begin
                chk({bus_a15, bus_addr_hi} == addr[15:8], "R8", k,
                    16'({bus_a15, bus_addr_hi}), 16'(addr[15:8]));
                chk(bus_addr_lo == (mux ? 8'h00 : addr[7:0]), mux ? "R10" : "R9", k,
                    16'(bus_addr_lo), 16'(mux ? 8'h00 : addr[7:0]));
            end
            if (k == s + w + 1 || k == tot) begin
                if (!wr) exp_rdata = rv;
                chk(rsp_rdata == exp_rdata, "R7", k, 16'(rsp_rdata), 16'(exp_rdata));
            end
            // drive for the edge that ends cycle k
            bus_data_i = (k == s + w) ? rv : ~rv;
            if (k == 1) begin
                req_addr = ~addr; req_write = ~wr;  // ignored while busy (R6)
                if (chg_cfg) begin
                    cfg_we = 1'b1; cfg_wdata = ~cfg_val;  // R12
                end
            end else if (k == 2) begin
                req_valid = 1'b0; cfg_we = 1'b0;
                req_addr = addr; req_write = wr;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_rd_n && bus_wr_n, "R1", 0, 16'({bus_rd_n, bus_wr_n}), 16'h3);
        chk(bus_cs0_n && bus_cs1_n, "R1", 0, 16'({bus_cs0_n, bus_cs1_n}), 16'h3);
        chk(!bus_ale && !bus_data_oe, "R1", 0, 16'({bus_ale, bus_data_oe}), 16'h0);
        chk(!rsp_done, "R1", 0, 16'(rsp_done), 16'h0);
        chk(rsp_rdata == 8'h00, "R1", 0, 16'(rsp_rdata), 16'h0);
        rst = 1'b0;
        // R1: reset configuration FFh gives the longest timing in both sets
        do_access(8'hFF, 1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5, 1'b0);
        do_access(8'hFF, 1'b0, 1'b1, 1'b1, 16'hC3C3, 8'h5E, 8'h11, 1'b0);
        // R8 boundaries of the select regions
        do_access(8'h5A, 1'b1, 1'b0, 1'b0, 16'h3FFF, 8'h00, 8'h3C, 1'b0);
        do_access(8'h5A, 1'b1, 1'b0, 1'b1, 16'h4000, 8'h77, 8'h00, 1'b0);
        do_access(8'h5A, 1'b1, 1'b1, 1'b0, 16'h7FFF, 8'h00, 8'hC1, 1'b0);
        do_access(8'h5A, 1'b1, 1'b1, 1'b1, 16'h8000, 8'h99, 8'h00, 1'b0);
        do_access(8'h5A, 1'b1, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h6D, 1'b0);
        do_access(8'h5A, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h2B, 1'b0);
        // sweep every configuration byte, both sets, both modes, both directions
        for (int c = 0; c < 256; c++) begin
            for (int v = 0; v < 8; v++) begin
                logic [15:0] a;
                int idx;
                idx = c * 8 + v;
                if (v[2])
                    a = 16'h8000 | (16'(idx * 403) & 16'h7FFF);
                else
                    a = (v[0] ? 16'h4000 : 16'h0000) | (16'(idx * 295) & 16'h3FFF);
                do_access(8'(c), 1'b1, v[1], v[0], a, 8'(idx * 7 + 3),
                          8'(idx * 13 + 1), (idx % 3) == 0);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule